// File: doc/BRIEF.md
# Charge-Pump Fast-Lock Interval Timer

This block sequences the fast-lock phase of a fractional-N synthesizer loop. When the loop's divider word is loaded while fast-lock is enabled, it raises a high-current request toward the charge pump and turns on an open-drain switch that shorts part of the loop filter. Both stay on for a programmed interval, and then the block drops back to the low steady-state current and opens the switch.

The interval is measured in blocks of 64 reference-clock cycles, and a 7-bit setting gives the number of blocks. A configuration bit can hold the filter switch permanently open, so that only the current boost is used. While power-save is asserted, the interval is cancelled and both requests are held low. The analog charge pump and the switch device are outside this block.

Top module: `spdup_timer`

## Requirements
- R1: During and directly after synchronous reset, `cp_hi_cur_o` and `filt_sw_on_o` are 0.
- R2: A cycle with `chan_load_i`=1, `boost_en_i`=1, `pwr_save_i`=0 and `boost_time_i`=T (T>0) sets `cp_hi_cur_o` to 1 from the next cycle, for exactly 64·T consecutive cycles. It then returns to 0.
- R3: A load with `boost_en_i`=0 produces no interval. If an interval is running, the load ends it, and `cp_hi_cur_o` is 0 from the next cycle.
- R4: With `sw_force_off_i`=0, `filt_sw_on_o` equals `cp_hi_cur_o` in every cycle.
- R5: With `sw_force_off_i`=1, `filt_sw_on_o` is 0, while `cp_hi_cur_o` still follows the interval.
- R6: A change of `boost_time_i` without a load leaves the running interval's length unchanged. The next load uses the new value.
- R7: A load with fast-lock enabled, made during a running interval, restarts the count, giving 64·T cycles from that load.
- R8: While `pwr_save_i`=1, both outputs are 0 and loads are ignored. After release, both stay 0 until the next enabled load.
- R9: A load with `boost_time_i`=0 produces no interval.
- R10: The largest setting, T=127, gives an interval of 8128 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_load_i | input | 1 | One-cycle strobe: new loop divider word loaded |
| boost_en_i | input | 1 | Fast-lock enable (1 = boost on load) |
| boost_time_i | input | 7 | Interval length in blocks of 64 cycles |
| sw_force_off_i | input | 1 | 1 = filter switch always open, 0 = switch follows interval |
| pwr_save_i | input | 1 | Power-save: cancel interval, force both requests low |
| cp_hi_cur_o | output | 1 | 1 = high charge-pump current, 0 = steady-state current |
| filt_sw_on_o | output | 1 | 1 = open-drain filter switch on |

## Verification
A wrong block count in the down-counter shows up as an interval that is too long or too short. This is an error in multiples of 64 cycles, visible at `cp_hi_cur_o` only when the output falls. A wrong phase in the 64-cycle prescaler gives an error of up to 63 cycles at the same falling edge. A failure to clear on a disabled load or on power-save shows one cycle after that stimulus, as a request that stays high. Intervals of several lengths are therefore compared cycle by cycle, including a restart, a silent time change and the maximum setting.

// File: rtl/spdup_pkg.sv
`timescale 1ns/1ps
package spdup_pkg;

    localparam int unsigned PRE_W_DEF = 6;   // 64 reference cycles per block
    localparam int unsigned TM_W_DEF  = 7;   // up to 127 blocks

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ARM   = 2'd1,
        CMD_CLEAR = 2'd2
    } tmr_cmd_e;

    typedef struct packed {
        logic hi_cur;
        logic sw_on;
    } boost_req_t;

    // Power-save dominates; an enabled load with a nonzero time arms;
    // any other load clears.
    function automatic tmr_cmd_e decode_cmd(input logic load,
                                            input logic en,
                                            input logic time_nz,
                                            input logic psave);
        tmr_cmd_e c;
        if (psave)                  c = CMD_CLEAR;
        else if (load && en && time_nz) c = CMD_ARM;
        else if (load)              c = CMD_CLEAR;
        else                        c = CMD_NONE;
        return c;
    endfunction

endpackage

// File: rtl/spdup_prescaler.sv
`timescale 1ns/1ps
module spdup_prescaler #(
    parameter int unsigned PRE_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    generate
        if (PRE_W == 0) begin : g_direct
            assign tick = run;
        end else begin : g_count
            logic [PRE_W-1:0] phase_q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    phase_q <= '0;
                else if (run)
                    phase_q <= phase_q + 1'b1;
            end
            assign tick = run && (phase_q == {PRE_W{1'b1}});
        end
    endgenerate
endmodule

// File: rtl/spdup_downcnt.sv
`timescale 1ns/1ps
module spdup_downcnt
    import spdup_pkg::*;
#(
    parameter int unsigned TM_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  tmr_cmd_e        cmd,
    input  logic [TM_W-1:0] load_val,
    input  logic            tick,
    output logic            active
);
    logic [TM_W-1:0] blocks_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blocks_q <= '0;
        end else begin
            unique case (cmd)
                CMD_ARM:   blocks_q <= load_val;
                CMD_CLEAR: blocks_q <= '0;
                default: begin
                    if (tick && (blocks_q != '0))
                        blocks_q <= blocks_q - 1'b1;
                end
            endcase
        end
    end

    assign active = (blocks_q != '0);
endmodule

// File: rtl/spdup_outdrv.sv
`timescale 1ns/1ps
module spdup_outdrv
    import spdup_pkg::*;
(
    input  logic       active,
    input  logic       sw_force_off,
    input  logic       psave,
    output boost_req_t req
);
    always_comb begin
        req.hi_cur = active && !psave;
        req.sw_on  = active && !psave && !sw_force_off;
    end
endmodule

// File: rtl/spdup_timer.sv
`timescale 1ns/1ps
module spdup_timer
    import spdup_pkg::*;
#(
    parameter int unsigned PRE_W = PRE_W_DEF,
    parameter int unsigned TM_W  = TM_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            chan_load_i,
    input  logic            boost_en_i,
    input  logic [TM_W-1:0] boost_time_i,
    input  logic            sw_force_off_i,
    input  logic            pwr_save_i,
    output logic            cp_hi_cur_o,
    output logic            filt_sw_on_o
);
    tmr_cmd_e   cmd;
    logic       tick;
    logic       active;
    boost_req_t req;

    assign cmd = decode_cmd(chan_load_i, boost_en_i,
                            (boost_time_i != '0), pwr_save_i);

    spdup_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (cmd != CMD_NONE),
        .run  (active),
        .tick (tick)
    );

    spdup_downcnt #(.TM_W(TM_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (boost_time_i),
        .tick     (tick),
        .active   (active)
    );

    spdup_outdrv u_out (
        .active       (active),
        .sw_force_off (sw_force_off_i),
        .psave        (pwr_save_i),
        .req          (req)
    );

    assign cp_hi_cur_o  = req.hi_cur;
    assign filt_sw_on_o = req.sw_on;
endmodule

// File: rtl/spdup_timer_chk.sv
`timescale 1ns/1ps
module spdup_timer_chk #(
    parameter int unsigned PRE_W = 6,
    parameter int unsigned TM_W  = 7
) (
    input logic            clk,
    input logic            rst,
    input logic            chan_load_i,
    input logic            boost_en_i,
    input logic [TM_W-1:0] boost_time_i,
    input logic            sw_force_off_i,
    input logic            pwr_save_i,
    input logic            cp_hi_cur_o,
    input logic            filt_sw_on_o
);
    logic [PRE_W+TM_W-1:0] hi_len_q;
    logic [TM_W-1:0]       tm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len_q <= '0;
            tm_q     <= '0;
        end else if (chan_load_i && !pwr_save_i) begin
            hi_len_q <= '0;
            tm_q     <= boost_en_i ? boost_time_i : '0;
        end else if (cp_hi_cur_o) begin
            hi_len_q <= hi_len_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!cp_hi_cur_o && !filt_sw_on_o));

    // R2
    rise_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_hi_cur_o) |-> $past(chan_load_i && boost_en_i));

    // R2
    interval_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cp_hi_cur_o) && !pwr_save_i && !$past(pwr_save_i) && !$past(chan_load_i))
        |-> (hi_len_q == {tm_q, {PRE_W{1'b0}}}));

    // R3
    disabled_load_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_load_i && !boost_en_i) |=> !cp_hi_cur_o);

    // R5
    forced_open_chk: assert property (@(posedge clk) disable iff (rst)
        sw_force_off_i |-> !filt_sw_on_o);

    // R4
    sw_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_force_off_i |-> (filt_sw_on_o == cp_hi_cur_o));

    // R8
    psave_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_save_i |=> (!cp_hi_cur_o && !filt_sw_on_o));

    // R9
    zero_time_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_load_i && (boost_time_i == '0)) |=> !cp_hi_cur_o);
endmodule

bind spdup_timer spdup_timer_chk #(.PRE_W(PRE_W), .TM_W(TM_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .chan_load_i    (chan_load_i),
    .boost_en_i     (boost_en_i),
    .boost_time_i   (boost_time_i),
    .sw_force_off_i (sw_force_off_i),
    .pwr_save_i     (pwr_save_i),
    .cp_hi_cur_o    (cp_hi_cur_o),
    .filt_sw_on_o   (filt_sw_on_o)
);

// File: tb/spdup_timer_tb.sv
`timescale 1ns/1ps
module spdup_timer_tb;

    typedef struct {
        logic  hi;
        logic  sw;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       chan_load;
    logic       boost_en;
    logic [6:0] boost_time;
    logic       sw_off;
    logic       psave;
    logic       hi_cur;
    logic       sw_on;

    // test-side settings, applied to the DUT at the next falling edge
    logic       g_rst  = 1'b1;
    logic       g_en   = 1'b0;
    logic [6:0] g_tm   = '0;
    logic       g_hold = 1'b0;
    logic       g_ps   = 1'b0;

    exp_t q[$];
    int   checks   = 0;
    int   failures = 0;
    int   remain   = 0;
    bit   done     = 1'b0;

    always #2.5 clk = ~clk;

    spdup_timer u_dut (
        .clk            (clk),
        .rst            (rst),
        .chan_load_i    (chan_load),
        .boost_en_i     (boost_en),
        .boost_time_i   (boost_time),
        .sw_force_off_i (sw_off),
        .pwr_save_i     (psave),
        .cp_hi_cur_o    (hi_cur),
        .filt_sw_on_o   (sw_on)
    );

    // driver: one cycle of stimulus plus its expected result
    task automatic cyc(input bit ld, input string tag);
        exp_t e;
        @(negedge clk);
        rst        = g_rst;
        chan_load  = ld;
        boost_en   = g_en;
        boost_time = g_tm;
        sw_off     = g_hold;
        psave      = g_ps;
        if (g_rst || g_ps)      remain = 0;
        else if (ld)            remain = (g_en && g_tm != 0) ? 64 * int'(g_tm) : 0;
        else if (remain > 0)    remain = remain - 1;
        e.hi  = (remain > 0) && !g_ps;
        e.sw  = e.hi && !g_hold;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, tag);
    endtask

    // monitor: samples 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (hi_cur !== e.hi || sw_on !== e.sw) begin
                    failures++;
                    $display("FAIL %s: hi_cur=%b sw_on=%b expected hi_cur=%b sw_on=%b at %0t",
                             e.tag, hi_cur, sw_on, e.hi, e.sw, $time);
                end
            end
        end
    end

    initial begin
        rst = 1'b1; chan_load = 1'b0; boost_en = 1'b0;
        boost_time = '0; sw_off = 1'b0; psave = 1'b0;

        run(4, "R1");                       // R1 reset state
        g_rst = 1'b0;
        run(3, "R1");

        g_en = 1'b1; g_tm = 7'd2;           // R2 / R4: 128-cycle interval
        cyc(1'b1, "R2");
        run(140, "R4");

        g_hold = 1'b1; g_tm = 7'd1;         // R5 switch forced open
        cyc(1'b1, "R5");
        run(70, "R5");
        g_hold = 1'b0;

        g_tm = 7'd3;                        // R6 time change without load
        cyc(1'b1, "R6");
        run(50, "R6");
        g_tm = 7'd5;
        run(160, "R6");
        cyc(1'b1, "R6");                    // R6 next load uses 5 blocks
        run(330, "R6");

        g_tm = 7'd2;                        // R7 restart mid-interval
        cyc(1'b1, "R7");
        run(100, "R7");
        cyc(1'b1, "R7");
        run(140, "R7");

        g_tm = 7'd4;                        // R3 disabled load ends interval
        cyc(1'b1, "R3");
        run(30, "R3");
        g_en = 1'b0;
        cyc(1'b1, "R3");
        run(10, "R3");
        cyc(1'b1, "R3");                    // R3 disabled load while idle
        run(10, "R3");
        g_en = 1'b1;

        cyc(1'b1, "R8");                    // R8 power-save cancels
        run(20, "R8");
        g_ps = 1'b1;
        run(2, "R8");
        cyc(1'b1, "R8");                    // R8 load ignored in power-save
        run(3, "R8");
        g_ps = 1'b0;
        run(20, "R8");

        g_tm = 7'd0;                        // R9 zero time
        cyc(1'b1, "R9");
        run(20, "R9");

        g_tm = 7'd127;                      // R10 maximum interval
        cyc(1'b1, "R10");
        run(8140, "R10");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule